// File: doc/BRIEF.md
# Tagged-Shift Serial Byte Transmitter

This block turns a byte written over a parallel interface into one asynchronous serial frame. The frame is one low start bit, then the eight data bits least significant first, then a parity bit, then one high stop bit. Every bit lasts one baud period. The baud period is `OVERSAMPLE` cycles of the master clock, which runs at 16 times the baud rate by default.

A write is taken on the rising edge of a strobe. The byte and its parity mode are captured together into a hold register, and a ready flag drops. On the next baud edge on which the serial engine is free, the held byte moves into a shift register and the start bit goes out. At the same moment the ready flag rises again, so software can queue the next byte while the current frame is still running.

The shift register has two marker bits above the data bits. Zeros fill in from the top as the register shifts. The engine finds the parity slot, the stop bit and the end of the frame from where the markers sit, without any bit counter.

Top module: `uart_tag_tx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `tx` is 1 and `tx_rdy` is 1.
- R2: `tx` changes only on baud edges. A baud edge is every `OVERSAMPLE`-th rising clock edge counted from reset release, so edges numbered 16, 32, 48 and so on with the defaults.
- R3: A byte is captured only on a 0-to-1 change of `wr_stb`. Holding the strobe high for many cycles sends exactly one frame.
- R4: A frame is a start bit of 0, then `wr_data[0]` through `wr_data[7]` in that order, then the parity bit, then a stop bit of 1. Each bit lasts `OVERSAMPLE` cycles.
- R5: The parity bit equals the XOR of the eight data bits, XORed with `odd_par`. `odd_par` = 1 selects odd parity and 0 selects even parity. The mode is captured together with the byte.
- R6: A write captured on edge w with the line idle starts its frame on the first baud edge strictly after w. `tx_rdy` is 0 from edge w until that baud edge and 1 right after it.
- R7: `tx` is 1 whenever no frame is being sent.
- R8: A byte written while a frame is in progress waits in the hold register. It starts on the first baud edge after the current stop bit, so back-to-back frames begin exactly 11 baud periods apart.
- R9: A second write before the held byte has been loaded replaces it. Only the last byte is sent.
- R10: If a write is captured on the same edge that loads the held byte, the older byte is the one sent. The new byte stays held, `tx_rdy` stays 0, and the new byte follows as the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock at OVERSAMPLE times the baud rate |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Write strobe; its rising edge captures a byte |
| wr_data | input | DATA_W | Byte to transmit |
| odd_par | input | 1 | Parity mode for the byte being written: 1 odd, 0 even |
| tx | output | 1 | Serial line, idle high |
| tx_rdy | output | 1 | High when the hold register can take a new byte |

## Verification
The two functions that can meet in one cycle are the capture of a new write and the move of the held byte into the shift register.

The bench queues one byte behind a running frame. It then times a second strobe so that its capture edge is exactly the baud edge on which the first queued byte loads. This edge is computed from the cycle count since reset.

The result is judged at the ports. The queued byte must start at that edge, `tx_rdy` must stay low, and the later byte must start exactly one frame (176 cycles) later with its own data and parity.

// File: rtl/uart_tag_tx_pkg.sv
package uart_tag_tx_pkg;

  // Two marker bits sit above the data bits in the shift register.
  localparam int unsigned TAG_BITS = 2;

  typedef enum logic [1:0] {
    TXM_IDLE  = 2'd0,
    TXM_LOAD  = 2'd1,
    TXM_SHIFT = 2'd2
  } txm_e;

  function automatic txm_e txm_decode(input logic load, input logic done);
    txm_e m;
    if (load)       m = TXM_LOAD;
    else if (!done) m = TXM_SHIFT;
    else            m = TXM_IDLE;
    return m;
  endfunction

endpackage

// File: rtl/uart_tag_baud_div.sv
module uart_tag_baud_div #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (OVERSAMPLE > 1) begin : g_gap_chk
      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/uart_tag_hold.sv
module uart_tag_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              odd_i,
  input  logic              tick_i,
  input  logic              done_i,
  output logic              load_o,
  output logic [DATA_W-1:0] data_o,
  output logic              odd_o,
  output logic              rdy_o
);
  logic wr_q;
  logic pend_q;
  logic pend_d;
  logic wr_rise;

  assign wr_rise = wr_stb_i & ~wr_q;
  assign load_o  = tick_i & done_i & pend_q;

  always_comb begin
    pend_d = pend_q;
    if (wr_rise)     pend_d = 1'b1;
    else if (load_o) pend_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      pend_q <= 1'b0;
      rdy_o  <= 1'b1;
      data_o <= '0;
      odd_o  <= 1'b0;
    end else begin
      wr_q   <= wr_stb_i;
      pend_q <= pend_d;
      rdy_o  <= ~pend_d;
      if (wr_rise) begin
        data_o <= wr_data_i;
        odd_o  <= odd_i;
      end
    end
  end

  // R6
  rdy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    wr_rise |=> !rdy_o);
  // R6
  rdy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (load_o && !wr_rise) |=> rdy_o);
  // R10
  coincide_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (load_o && wr_rise) |=> (!rdy_o && !load_o));

endmodule

// File: rtl/uart_tag_shift.sv
module uart_tag_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              odd_i,
  output logic              done_o,
  output logic              tx_o
);
  import uart_tag_tx_pkg::*;

  localparam int unsigned SR_W = DATA_W + TAG_BITS;

  logic [SR_W-1:0] sreg_q;
  logic            par_q;
  logic            par_slot;

  // The frame is over once both markers have left the register.
  assign done_o   = (sreg_q == '0);
  // The second marker at bit 1, with nothing above it, marks the parity slot.
  assign par_slot = (sreg_q[SR_W-1:2] == '0) && sreg_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      par_q  <= 1'b0;
      tx_o   <= 1'b1;
    end else if (tick_i) begin
      if (load_i) begin
        sreg_q <= {{TAG_BITS{1'b1}}, data_i};
        par_q  <= odd_i;
        tx_o   <= 1'b0;
      end else if (!done_o) begin
        sreg_q <= {1'b0, sreg_q[SR_W-1:1]};
        if (par_slot) begin
          tx_o <= par_q;
        end else begin
          tx_o  <= sreg_q[0];
          par_q <= par_q ^ sreg_q[0];
        end
      end else begin
        tx_o <= 1'b1;
      end
    end
  end

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(tx_o));
  // R4
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !tx_o);
  // R8
  load_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |-> done_o);
  // R5
  tag_pair_chk: assert property (@(posedge clk) disable iff (rst)
    par_slot |-> sreg_q[0]);

endmodule

// File: rtl/uart_tag_tx.sv
module uart_tag_tx #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              odd_par,
  output logic              tx,
  output logic              tx_rdy
);
  import uart_tag_tx_pkg::*;

  logic              tick;
  logic              load;
  logic              done;
  logic [DATA_W-1:0] held_data;
  logic              held_odd;
  txm_e              mode;

  uart_tag_baud_div #(.OVERSAMPLE(OVERSAMPLE)) u_div (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  uart_tag_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .wr_stb_i  (wr_stb),
    .wr_data_i (wr_data),
    .odd_i     (odd_par),
    .tick_i    (tick),
    .done_i    (done),
    .load_o    (load),
    .data_o    (held_data),
    .odd_o     (held_odd),
    .rdy_o     (tx_rdy)
  );

  uart_tag_shift #(.DATA_W(DATA_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick),
    .load_i (load),
    .data_i (held_data),
    .odd_i  (held_odd),
    .done_o (done),
    .tx_o   (tx)
  );

  assign mode = txm_decode(load, done);

  // R7
  idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == TXM_IDLE) |-> tx);

endmodule

// File: tb/test_uart_tag_tx.sv
module test_uart_tag_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       odd_par = 1'b0;
  logic       tx;
  logic       tx_rdy;

  uart_tag_tx i_uart_tag_tx (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .odd_par(odd_par), .tx(tx), .tx_rdy(tx_rdy)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n;  // rising edges since reset release
  always @(posedge clk) begin
    if (rst) n <= 0;
    else     n <= n + 1;
  end

  int compared = 0;
  int mismatched = 0;
  int frames = 0;
  int exp_q[$];
  int starts[$];
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // called on a negedge; capture happens on the next rising edge
  task automatic pulse_write(input logic [7:0] d, input bit odd, output int cap);
    cap = n + 1;
    wr_data = d; odd_par = odd; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_frames(input int k);
    while (frames < k) @(negedge clk);
  endtask

  // serial line monitor: decodes frames, compares with the expected queue
  initial begin : rx_mon
    int s;
    int e;
    logic [10:0] bits;
    logic [7:0] d;
    bit odd;
    wait (!rst);
    forever begin
      @(negedge clk);
      if (tx === 1'b0) begin
        s = n;
        check((s % 16) == 0, "R2", "start edge phase", s % 16, 0);
        repeat (8) @(negedge clk);
        bits[0] = tx;
        for (int k = 1; k < 11; k++) begin
          repeat (16) @(negedge clk);
          bits[k] = tx;
        end
        if (exp_q.size() == 0) begin
          check(0, "R3", "unexpected frame", int'(bits[8:1]), -1);
        end else begin
          e = exp_q.pop_front();
          d = e[7:0];
          odd = e[8];
          check(bits[0] == 1'b0, "R4", "start bit", bits[0], 0);
          check(bits[8:1] == d, "R4", "data bits", bits[8:1], d);
          check(bits[9] == (^d ^ odd), "R5", "parity bit", bits[9], ^d ^ odd);
          check(bits[10] == 1'b1, "R4", "stop bit", bits[10], 1);
        end
        starts.push_back(s);
        frames++;
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin : stim
    int cap;
    int cap2;
    int expst;
    int f0;
    int hi;
    int offs[4] = '{0, 1, 7, 15};

    // R1 reset state
    repeat (3) @(negedge clk);
    check(tx === 1'b1, "R1", "tx in reset", tx, 1);
    check(tx_rdy === 1'b1, "R1", "tx_rdy in reset", tx_rdy, 1);
    rst = 1'b0;
    @(negedge clk);
    check(tx === 1'b1 && tx_rdy === 1'b1, "R1", "after release", {tx, tx_rdy}, 3);

    // R7 idle line stays high
    hi = 0;
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      if (tx === 1'b1) hi++;
    end
    check(hi == 48, "R7", "idle high cycles", hi, 48);

    // R6 load latency across capture phases
    foreach (offs[j]) begin
      do @(negedge clk); while (((n + 1) % 16) != offs[j]);
      f0 = frames;
      exp_q.push_back({23'd0, 1'b1, 8'hA5 ^ 8'(j)});
      pulse_write(8'hA5 ^ 8'(j), 1'b1, cap);
      check(tx_rdy == 1'b0, "R6", "ready low after capture", tx_rdy, 0);
      expst = (cap / 16 + 1) * 16;
      while (n < expst) @(negedge clk);
      check(tx_rdy == 1'b1, "R6", "ready high at load", tx_rdy, 1);
      check(tx == 1'b0, "R6", "start at load edge", tx, 0);
      wait_frames(f0 + 1);
      check(starts[f0] == expst, "R6", "frame start edge", starts[f0], expst);
      repeat (20) @(negedge clk);
    end

    // R8 back-to-back sweep over all byte values, both parity modes
    f0 = frames;
    for (int i = 0; i < 256; i++) begin
      do @(negedge clk); while (!tx_rdy);
      exp_q.push_back({23'd0, 1'(i[0] ^ i[3]), 8'(i)});
      pulse_write(8'(i), 1'(i[0] ^ i[3]), cap);
    end
    wait_frames(f0 + 256);
    for (int j = f0 + 1; j < f0 + 256; j++)
      check(starts[j] - starts[j-1] == 176, "R8", "frame spacing",
            starts[j] - starts[j-1], 176);
    repeat (40) @(negedge clk);

    // R9 second write before load replaces held byte
    f0 = frames;
    exp_q.push_back({23'd0, 1'b0, 8'h3C});
    pulse_write(8'h3C, 1'b0, cap);
    do @(negedge clk); while (tx !== 1'b0);
    repeat (5) @(negedge clk);
    pulse_write(8'h11, 1'b0, cap2);
    repeat (5) @(negedge clk);
    exp_q.push_back({23'd0, 1'b1, 8'hE7});
    pulse_write(8'hE7, 1'b1, cap2);
    wait_frames(f0 + 2);
    check(starts[f0+1] - starts[f0] == 176, "R9", "replacement start",
          starts[f0+1] - starts[f0], 176);
    repeat (300) @(negedge clk);
    check(frames == f0 + 2, "R9", "frame count", frames - f0, 2);

    // R10 write captured on the same edge as a load
    f0 = frames;
    exp_q.push_back({23'd0, 1'b0, 8'h81});
    pulse_write(8'h81, 1'b0, cap);
    expst = (cap / 16 + 1) * 16;
    while (n < expst + 20) @(negedge clk);
    exp_q.push_back({23'd0, 1'b1, 8'h5A});
    pulse_write(8'h5A, 1'b1, cap2);
    while (n < expst + 175) @(negedge clk);
    exp_q.push_back({23'd0, 1'b0, 8'hC3});
    pulse_write(8'hC3, 1'b0, cap2);
    check(cap2 == expst + 176, "R10", "capture edge", cap2, expst + 176);
    check(tx_rdy == 1'b0, "R10", "ready stays low", tx_rdy, 0);
    check(tx == 1'b0, "R10", "older byte starts", tx, 0);
    wait_frames(f0 + 3);
    check(starts[f0+1] == expst + 176, "R10", "second start", starts[f0+1], expst + 176);
    check(starts[f0+2] == expst + 352, "R10", "third start", starts[f0+2], expst + 352);
    repeat (40) @(negedge clk);

    // R3 long strobe sends one frame only
    f0 = frames;
    exp_q.push_back({23'd0, 1'b1, 8'h96});
    wr_data = 8'h96; odd_par = 1'b1; wr_stb = 1'b1;
    repeat (40) @(negedge clk);
    wr_stb = 1'b0;
    wait_frames(f0 + 1);
    repeat (400) @(negedge clk);
    check(frames == f0 + 1, "R3", "frames for held strobe", frames - f0, 1);
    check(tx == 1'b1, "R7", "line high after frames", tx, 1);
    check(exp_q.size() == 0, "R4", "frames left unsent", exp_q.size(), 0);

    finish_run();
  end

endmodule